// File: doc/BRIEF.md
# Lazy Register-Context Migration Controller

This controller sits on the receiving core when a thread moves from one core to another. It does not copy the whole register file at once. When a migration begins, the sending core hands over a bitmap of the registers the thread actually uses. The program counter and the two top registers, r30 and r31, come across eagerly on a separate path with that bitmap, so their bits are retired as soon as the map is loaded. Every other marked register stays pending until the thread needs it.

While the thread runs on the new core, each instruction is checked against the pending map. A source operand that is still pending stalls the instruction, and the controller asks the old core for it. When several operands are pending, it fetches them lowest index first, with one request in flight at a time. A register that the thread writes before it ever reads it is retired without any transfer. If the map is still not empty after a set number of retired instructions, the controller stops waiting for demand and pulls every remaining register in ascending order. When nothing is left pending and no request is in flight, it raises a one-cycle pulse that tells the old core to go idle and discard its copy.

Top module: `ctx_pull_ctrl`

## Requirements
- R1: After reset the controller is idle: no request is raised, the done pulse is low, and instructions are never stalled.
- R2: A start pulse while idle loads the usage map with bits 30 and 31 cleared, as those registers arrive eagerly. If no other bit is set, the done pulse rises in the cycle right after the start is captured, and no request is made.
- R3: An instruction whose enabled source register is pending has ins_ready held low. A request naming that 5-bit index is raised, and the response data comes out on the register-file write port with its index.
- R4: When both operands of an instruction are pending, they are requested in ascending index order. A second request never begins in the cycle after a request is accepted.
- R5: A retired instruction with an enabled destination clears that register's pending bit, and no request is ever made for it.
- R6: A response for a register whose bit was already cleared is accepted but gives no register-file write.
- R7: After LIMIT instructions have retired since the start, every register still pending is requested in ascending order, with no instruction asking for it. Before that count no demand-free request appears.
- R8: The done pulse is one cycle wide and comes once per migration. It comes in the cycle after the response that satisfied the last pending register.
- R9: A start pulse while a migration is in progress is ignored. Its map is never requested and it gives no second done pulse.
- R10: Reset during a migration clears the pending map and returns the controller to idle. No done pulse and no request follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a migration (taken only when idle) |
| src_map | input | NREG | Usage bitmap sent by the old core |
| ins_valid | input | 1 | An instruction is ready to retire |
| ins_rs1_en | input | 1 | First source operand is used |
| ins_rs1 | input | IW | First source register index |
| ins_rs2_en | input | 1 | Second source operand is used |
| ins_rs2 | input | IW | Second source register index |
| ins_rd_en | input | 1 | Instruction writes a destination register |
| ins_rd | input | IW | Destination register index |
| ins_ready | output | 1 | Instruction may retire this cycle |
| req_valid | output | 1 | Register fetch request to the old core |
| req_ready | input | 1 | Old core accepts the request |
| req_idx | output | IW | Index of the requested register |
| rsp_valid | input | 1 | Register value returned by the old core |
| rsp_ready | output | 1 | Controller accepts the response |
| rsp_idx | input | IW | Index of the returned register |
| rsp_data | input | DW | Returned register value |
| rf_we | output | 1 | Write strobe into the local register file |
| rf_idx | output | IW | Write index |
| rf_data | output | DW | Write data |
| handoff_done | output | 1 | One-cycle pulse: old core may go idle and drop its context |

## Verification
The bench goes after the cases where operand order and local writes interact. An instruction names its larger pending operand first. A design that followed operand slots instead of index order would request them in the wrong order. In another case a destination is written while its fetch is still in flight. A design that did not check the map on the response would write stale data over the new value. The bench also counts retired instructions up to the drain limit and checks the exact cycle of the done pulse. Either check catches a counter that is off by one or a done that is late or repeated. A sweep over every single-register map confirms that the index decoding reaches each register.

// File: rtl/ctx_pull_ctrl.sv
module ctx_pull_ctrl #(
  parameter int NREG = 32,
  parameter int DW = 64,
  parameter int LIMIT = 256,
  parameter logic [NREG-1:0] EAGER = {2'b11, {(NREG-2){1'b0}}},
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NREG-1:0] src_map,
  input  logic            ins_valid,
  input  logic            ins_rs1_en,
  input  logic [IW-1:0]   ins_rs1,
  input  logic            ins_rs2_en,
  input  logic [IW-1:0]   ins_rs2,
  input  logic            ins_rd_en,
  input  logic [IW-1:0]   ins_rd,
  output logic            ins_ready,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [IW-1:0]   req_idx,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  input  logic [IW-1:0]   rsp_idx,
  input  logic [DW-1:0]   rsp_data,
  output logic            rf_we,
  output logic [IW-1:0]   rf_idx,
  output logic [DW-1:0]   rf_data,
  output logic            handoff_done
);

  logic            active, drain, outst;
  logic [NREG-1:0] pend;
  logic [CW-1:0]   cnt;

  logic [NREG-1:0] ops_mask, ops_pend, need, wr_clear, rsp_clear;
  logic            retire, rsp_acc;

  assign ops_mask = ({NREG{ins_rs1_en}} & (NREG'(1) << ins_rs1)) |
                    ({NREG{ins_rs2_en}} & (NREG'(1) << ins_rs2));
  assign ops_pend = {NREG{active}} & pend & ops_mask;
  assign ins_ready = (ops_pend == '0);

  assign need = !active ? '0 : drain ? pend : (ins_valid ? ops_pend : '0);

  always_comb begin
    req_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (need[i]) req_idx = IW'(i);
  end

  assign req_valid    = active && !outst && (need != '0);
  assign rsp_ready    = outst;
  assign rsp_acc      = rsp_valid && rsp_ready;
  assign rf_we        = rsp_acc && pend[rsp_idx];
  assign rf_idx       = rsp_idx;
  assign rf_data      = rsp_data;
  assign retire       = active && ins_valid && ins_ready;
  assign handoff_done = active && (pend == '0) && !outst;

  assign wr_clear  = (retire && ins_rd_en) ? (NREG'(1) << ins_rd) : '0;
  assign rsp_clear = rf_we ? (NREG'(1) << rsp_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      drain  <= 1'b0;
      outst  <= 1'b0;
      pend   <= '0;
      cnt    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        drain  <= 1'b0;
        outst  <= 1'b0;
        pend   <= src_map & ~EAGER;
        cnt    <= '0;
      end
    end else if (handoff_done) begin
      active <= 1'b0;
      drain  <= 1'b0;
    end else begin
      if (req_valid && req_ready) outst <= 1'b1;
      else if (rsp_acc) outst <= 1'b0;
      pend <= pend & ~rsp_clear & ~wr_clear;
      if (retire && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
      if (retire && cnt == CW'(LIMIT - 1)) drain <= 1'b1;
    end
  end

  assert_req_is_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> pend[req_idx]);

  assert_stall_makes_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ins_valid && !ins_ready) |-> (req_valid || outst));

  assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  assert_map_only_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ((pend & ~$past(pend)) == '0));

  assert_drain_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && req_valid) |-> ((pend & ((NREG'(1) << req_idx) - NREG'(1))) == '0));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_done |=> !handoff_done);

endmodule

// File: tb/tb_ctx_pull_ctrl.sv
module tb_ctx_pull_ctrl;
  localparam int NREG = 32;
  localparam int DW = 64;
  localparam int IW = 5;
  localparam int LIM = 8;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [NREG-1:0] src_map = '0;
  logic ins_valid = 0, ins_rs1_en = 0, ins_rs2_en = 0, ins_rd_en = 0;
  logic [IW-1:0] ins_rs1 = '0, ins_rs2 = '0, ins_rd = '0;
  logic ins_ready, req_valid, rsp_ready, rf_we, handoff_done;
  logic req_ready = 1;
  logic [IW-1:0] req_idx, rf_idx;
  logic rsp_valid = 0;
  logic [IW-1:0] rsp_idx = '0;
  logic [DW-1:0] rsp_data = '0, rf_data;

  ctx_pull_ctrl #(.NREG(NREG), .DW(DW), .LIMIT(LIM)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int reqlog[0:255];
  int nreq = 0, done_cnt = 0, cyc = 0, last_we_cyc = -1, done_cyc = -1;
  logic [NREG-1:0] wmask = '0;
  logic [DW-1:0] got[0:NREG-1];

  function automatic logic [DW-1:0] val(input int i);
    return {32'hC0DE_0000 | 32'(i), ~32'(i) ^ 32'h1357_9BDF};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    nreq = 0; done_cnt = 0; wmask = '0; last_we_cyc = -1; done_cyc = -1;
  endtask

  task automatic do_start(input logic [NREG-1:0] m);
    @(posedge clk); #1 start = 1; src_map = m;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic issue(input bit e1, input int r1, input bit e2, input int r2, input bit ed, input int rd);
    int t;
    @(posedge clk); #1;
    ins_valid = 1; ins_rs1_en = e1; ins_rs1 = IW'(r1);
    ins_rs2_en = e2; ins_rs2 = IW'(r2); ins_rd_en = ed; ins_rd = IW'(rd);
    t = 0;
    do begin @(negedge clk); t++; end while (!ins_ready && t < 200);
    @(posedge clk); #1;
    ins_valid = 0; ins_rs1_en = 0; ins_rs2_en = 0; ins_rd_en = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    if (rf_we) begin got[rf_idx] = rf_data; wmask[rf_idx] = 1'b1; last_we_cyc = cyc; end
    if (handoff_done) begin done_cnt++; done_cyc = cyc; end
    if (req_valid && req_ready && nreq < 256) begin reqlog[nreq] = int'(req_idx); nreq++; end
  end

  initial forever begin
    logic [IW-1:0] k;
    @(negedge clk);
    if (req_valid && req_ready) begin
      k = req_idx;
      repeat (3) @(posedge clk);
      #1 rsp_valid = 1; rsp_idx = k; rsp_data = val(int'(k));
      @(posedge clk);
      #1 rsp_valid = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    ins_valid = 1; ins_rs1_en = 1; ins_rs1 = 5'd4;
    @(negedge clk);
    chk(req_valid == 0, "R1 req_valid idle", req_valid, 0);
    chk(handoff_done == 0, "R1 done idle", handoff_done, 0);
    chk(ins_ready == 1, "R1 ready idle", ins_ready, 1);
    @(posedge clk); #1 ins_valid = 0; ins_rs1_en = 0;

    // R2 eager-only map
    clear_logs();
    do_start(32'hC000_0000);
    @(negedge clk); #2;
    chk(handoff_done == 1, "R2 done after eager-only start", handoff_done, 1);
    @(negedge clk); #2;
    chk(handoff_done == 0, "R8 done one cycle", handoff_done, 0);
    chk(nreq == 0, "R2 no request for eager regs", nreq, 0);

    // R3 R4 R5 R9 demand path
    clear_logs();
    do_start((32'd1 << 2) | (32'd1 << 5) | (32'd1 << 10) | (32'd1 << 11) | (32'd1 << 30));
    issue(1, 11, 1, 10, 1, 5);
    settle(2);
    chk(nreq == 2, "R4 two requests", nreq, 2);
    chk(reqlog[0] == 10, "R4 first ascending", reqlog[0], 10);
    chk(reqlog[1] == 11, "R4 second ascending", reqlog[1], 11);
    chk(wmask == ((32'd1 << 10) | (32'd1 << 11)), "R3 written regs", wmask, (32'd1 << 10) | (32'd1 << 11));
    chk(got[10] == val(10), "R3 data r10", got[10], val(10));
    chk(got[11] == val(11), "R3 data r11", got[11], val(11));
    chk(done_cnt == 0, "R8 not done while r2 pending", done_cnt, 0);
    do_start(32'd1 << 20);
    issue(1, 2, 0, 0, 0, 0);
    settle(10);
    chk(nreq == 3 && reqlog[2] == 2, "R3 fetch r2", nreq, 3);
    chk(done_cnt == 1, "R8 single done", done_cnt, 1);
    chk(done_cyc == last_we_cyc + 1, "R8 done timing", done_cyc, last_we_cyc + 1);
    seen = 0;
    for (int i = 0; i < nreq; i++) if (reqlog[i] == 5 || reqlog[i] == 20 || reqlog[i] == 30) seen = 1;
    chk(!seen, "R5 R9 no request for r5 r20 r30", seen, 0);
    settle(10);
    chk(done_cnt == 1 && nreq == 3, "R9 ignored start left no work", done_cnt, 1);

    // R6 R7 drain with discarded response
    clear_logs();
    do_start((32'd1 << 1) | (32'd1 << 3) | (32'd1 << 7) | (32'd1 << 9));
    for (int i = 0; i < LIM - 1; i++) issue(0, 0, 0, 0, 1, 0);
    settle(5);
    chk(nreq == 0, "R7 no drain before limit", nreq, 0);
    issue(0, 0, 0, 0, 1, 0);
    begin
      int t = 0;
      while (nreq < 2 && t < 200) begin @(negedge clk); #2; t++; end
    end
    issue(0, 0, 0, 0, 1, 3);
    begin
      int t = 0;
      while (done_cnt < 1 && t < 200) begin @(negedge clk); #2; t++; end
    end
    chk(nreq == 4, "R7 drain count", nreq, 4);
    chk(reqlog[0] == 1 && reqlog[1] == 3 && reqlog[2] == 7 && reqlog[3] == 9,
        "R7 drain order", {reqlog[0][7:0], reqlog[1][7:0], reqlog[2][7:0], reqlog[3][7:0]}, 32'h01030709);
    chk(wmask == ((32'd1 << 1) | (32'd1 << 7) | (32'd1 << 9)), "R6 stale r3 discarded", wmask,
        (32'd1 << 1) | (32'd1 << 7) | (32'd1 << 9));
    chk(got[9] == val(9), "R7 data r9", got[9], val(9));
    chk(done_cnt == 1, "R8 done after drain", done_cnt, 1);

    // R10 reset mid-migration
    settle(4);
    clear_logs();
    do_start(32'd1 << 4);
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    settle(8);
    chk(done_cnt == 0, "R10 no done after reset", done_cnt, 0);
    ins_valid = 1; ins_rs1_en = 1; ins_rs1 = 5'd4;
    @(negedge clk); #2;
    chk(ins_ready == 1, "R10 r4 no longer pending", ins_ready, 1);
    chk(nreq == 0, "R10 no request", nreq, 0);
    @(posedge clk); #1 ins_valid = 0; ins_rs1_en = 0;

    // R3 R8 sweep over single-register maps
    for (int k = 0; k < 30; k++) begin
      clear_logs();
      do_start(32'd1 << k);
      issue(0, 0, 1, k, 0, 0);
      settle(3);
      chk(nreq == 1 && reqlog[0] == k, "R3 sweep request", reqlog[0], k);
      chk(got[k] == val(k) && wmask == (32'd1 << k), "R3 sweep data", got[k], val(k));
      chk(done_cnt == 1, "R8 sweep done", done_cnt, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule